// File: doc/BRIEF.md
# Segmented Descending Stack Engine

This block keeps the stack state of a real-mode style processor: a 16-bit segment register and a 16-bit stack offset. It turns push and pop commands from an outside sequencer into single-word transactions on a simple synchronous memory port. Each physical address is the segment value multiplied by sixteen plus the offset, kept to 20 bits. Because the offset is only 16 bits wide, every stack access stays inside the 64 KiB window that starts at the segment base.

The stack grows toward lower addresses. A push lowers the offset by one word and then writes at the new location. A pop reads at the current location and then raises the offset by one word. Loading the offset also records it as the empty mark. A pop issued while the offset still equals that mark is refused and flagged. Multi-word sequences such as a call or an interrupt frame are built by the sequencer as a series of single pushes or pops.

Top module: `seg_stack_engine`

## Requirements
- R1: After a synchronous active-high reset, the segment and offset both read 0, the empty mark is 0, busy is low and no memory request is pending. A pop issued right after reset is therefore flagged as an underflow.
- R2: A push (op_kind 2'b10) sets the offset to offset-2. It then issues exactly one write request (mem_we=1) carrying op_data at the address formed from the new offset.
- R3: A pop (op_kind 2'b11) issues one read request (mem_we=0) at the current offset. When the memory acknowledges, the read word appears on pop_data with pop_valid high for exactly one cycle, and the offset becomes offset+2.
- R4: mem_addr equals (segment << 4) + offset, truncated to 20 bits. For example, segment FFFFh with offset 001Eh gives 0000Eh.
- R5: Offset arithmetic wraps modulo 2^16. A push from offset 0000h leaves FFFEh, and the following pop returns the offset to 0000h.
- R6: op_kind 2'b00 loads the segment from op_data. op_kind 2'b01 loads the offset from op_data and also sets the empty mark. Neither load issues a memory request.
- R7: A pop issued while the offset equals the empty mark pulses underflow for one cycle, issues no memory request and leaves the offset unchanged.
- R8: busy is high from the cycle after a push or pop is accepted until the cycle after mem_ack. While busy, mem_req and mem_addr hold steady and any command offered on op_valid is ignored.
- R9: Starting from segment 5000h and offset 7000h, 6144 pushes leave the offset at 4000h. A further 4096 pops leave it at 6000h. The segment is unchanged and the popped words come back in reverse push order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Command strobe, taken when busy is low |
| op_kind | input | 2 | 00 load segment, 01 load offset, 10 push, 11 pop |
| op_data | input | 16 | Load value or word to push |
| busy | output | 1 | A memory transaction is outstanding |
| underflow | output | 1 | One-cycle pulse on a refused pop |
| pop_valid | output | 1 | One-cycle pulse when pop_data holds a popped word |
| pop_data | output | 16 | Popped word |
| seg_val | output | 16 | Current segment register |
| ptr_val | output | 16 | Current stack offset |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 write (push), 0 read (pop) |
| mem_addr | output | 20 | Physical word address |
| mem_wdata | output | 16 | Word to write |
| mem_ack | input | 1 | Memory completion strobe |
| mem_rdata | input | 16 | Read data, valid with mem_ack |

## Verification
The push and pop path is driven from three different segment and offset settings. A mid-range pair shows the basic decrement-before-write and read-before-increment order. A segment of FFFFh shows that the physical address wraps at 20 bits rather than carrying out. Offset zero shows the 16-bit wrap down to FFFEh and back. Pops right after reset, and pops after the stack has been drained back to its loaded offset, tell a correct empty check apart from one that only compares against zero. A command offered while busy separates proper blocking from a unit that accepts mid-transaction. A long run of thousands of pushes followed by fewer pops checks the final offsets against the stated values and confirms last-in-first-out data order.

// File: rtl/segstk_pkg.sv
package segstk_pkg;

    localparam int SEG_W     = 16;
    localparam int OFF_W     = 16;
    localparam int DATA_W    = 16;
    localparam int SEG_SHIFT = 4;
    localparam int PA_W      = SEG_W + SEG_SHIFT;

    localparam logic [OFF_W-1:0] PTR_STEP = OFF_W'(DATA_W / 8);

    typedef enum logic [1:0] {
        OP_SET_SEG = 2'b00,
        OP_SET_PTR = 2'b01,
        OP_PUSH    = 2'b10,
        OP_POP     = 2'b11
    } stk_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } stk_state_e;

    typedef struct packed {
        logic              valid;
        logic              wr;
        logic [OFF_W-1:0]  off;
        logic [DATA_W-1:0] wdata;
    } mem_req_t;

    function automatic logic [OFF_W-1:0] ptr_down(input logic [OFF_W-1:0] p);
        return p - PTR_STEP;
    endfunction

    function automatic logic [OFF_W-1:0] ptr_up(input logic [OFF_W-1:0] p);
        return p + PTR_STEP;
    endfunction

    function automatic logic [PA_W-1:0] phys_addr(input logic [SEG_W-1:0] seg,
                                                  input logic [OFF_W-1:0] off);
        logic [PA_W-1:0] base;
        logic [PA_W-1:0] ext;
        base = {seg, {SEG_SHIFT{1'b0}}};
        ext  = PA_W'(off);
        return base + ext;
    endfunction

endpackage

// File: rtl/segstk_regs.sv
module segstk_regs
    import segstk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             seg_we,
    input  logic [SEG_W-1:0] seg_wdata,
    input  logic             ptr_we,
    input  logic [OFF_W-1:0] ptr_wdata,
    input  logic             mark_we,
    output logic [SEG_W-1:0] seg_q,
    output logic [OFF_W-1:0] ptr_q,
    output logic [OFF_W-1:0] mark_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q  <= '0;
            ptr_q  <= '0;
            mark_q <= '0;
        end else begin
            if (seg_we)  seg_q  <= seg_wdata;
            if (ptr_we)  ptr_q  <= ptr_wdata;
            if (mark_we) mark_q <= ptr_wdata;
        end
    end

    // R6
    mark_follow_chk: assert property (@(posedge clk) disable iff (rst)
        mark_we |=> (mark_q == ptr_q));

endmodule

// File: rtl/segstk_agen.sv
module segstk_agen
    import segstk_pkg::*;
(
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    output logic [PA_W-1:0]  addr
);

    always_comb begin
        addr = phys_addr(seg, off);
    end

endmodule

// File: rtl/segstk_ctrl.sv
module segstk_ctrl
    import segstk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic [DATA_W-1:0] op_data,
    input  logic [OFF_W-1:0]  ptr_q,
    input  logic [OFF_W-1:0]  mark_q,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              seg_we,
    output logic [SEG_W-1:0]  seg_wdata,
    output logic              ptr_we,
    output logic [OFF_W-1:0]  ptr_wdata,
    output logic              mark_we,
    output mem_req_t          req_q,
    output logic              busy,
    output logic              pop_valid,
    output logic [DATA_W-1:0] pop_data,
    output logic              underflow
);

    stk_state_e state_q;
    stk_op_e    op;
    logic       accept;
    logic       at_mark;
    logic       rd_done;

    assign op      = stk_op_e'(op_kind);
    assign busy    = (state_q == ST_WAIT);
    assign accept  = op_valid && !busy;
    assign at_mark = (ptr_q == mark_q);
    assign rd_done = busy && mem_ack && !req_q.wr;

    always_comb begin
        seg_we    = 1'b0;
        seg_wdata = SEG_W'(op_data);
        ptr_we    = 1'b0;
        ptr_wdata = ptr_q;
        mark_we   = 1'b0;
        if (accept) begin
            case (op)
                OP_SET_SEG: seg_we = 1'b1;
                OP_SET_PTR: begin
                    ptr_we    = 1'b1;
                    mark_we   = 1'b1;
                    ptr_wdata = OFF_W'(op_data);
                end
                OP_PUSH: begin
                    ptr_we    = 1'b1;
                    ptr_wdata = ptr_down(ptr_q);
                end
                default: ;
            endcase
        end else if (rd_done) begin
            ptr_we    = 1'b1;
            ptr_wdata = ptr_up(ptr_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            req_q     <= '0;
            pop_valid <= 1'b0;
            pop_data  <= '0;
            underflow <= 1'b0;
        end else begin
            pop_valid <= 1'b0;
            underflow <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (op_valid) begin
                        if (op == OP_PUSH) begin
                            req_q   <= '{valid: 1'b1, wr: 1'b1,
                                         off: ptr_down(ptr_q), wdata: op_data};
                            state_q <= ST_WAIT;
                        end else if (op == OP_POP) begin
                            if (at_mark) begin
                                underflow <= 1'b1;
                            end else begin
                                req_q   <= '{valid: 1'b1, wr: 1'b0,
                                             off: ptr_q, wdata: '0};
                                state_q <= ST_WAIT;
                            end
                        end
                    end
                end
                ST_WAIT: begin
                    if (mem_ack) begin
                        req_q.valid <= 1'b0;
                        state_q     <= ST_IDLE;
                        if (!req_q.wr) begin
                            pop_valid <= 1'b1;
                            pop_data  <= mem_rdata;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R2
    push_step_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && op == OP_PUSH) |=> (ptr_q == OFF_W'($past(ptr_q) - 16'd2)));

    // R3
    pop_step_chk: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> (ptr_q == OFF_W'($past(ptr_q) + 16'd2)));

    // R3
    pop_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pop_valid |=> !pop_valid);

    // R7
    uf_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        underflow |-> (!req_q.valid && $stable(ptr_q)));

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_q.valid && !mem_ack) |=> (req_q.valid && $stable(req_q.off) && $stable(req_q.wr)));

endmodule

// File: rtl/seg_stack_engine.sv
module seg_stack_engine
    import segstk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [1:0]  op_kind,
    input  logic [15:0] op_data,
    output logic        busy,
    output logic        underflow,
    output logic        pop_valid,
    output logic [15:0] pop_data,
    output logic [15:0] seg_val,
    output logic [15:0] ptr_val,
    output logic        mem_req,
    output logic        mem_we,
    output logic [19:0] mem_addr,
    output logic [15:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [15:0] mem_rdata
);

    logic             seg_we;
    logic [SEG_W-1:0] seg_wdata;
    logic             ptr_we;
    logic [OFF_W-1:0] ptr_wdata;
    logic             mark_we;
    logic [SEG_W-1:0] seg_q;
    logic [OFF_W-1:0] ptr_q;
    logic [OFF_W-1:0] mark_q;
    mem_req_t         req_q;
    logic [PA_W-1:0]  pa;

    segstk_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .op_valid  (op_valid),
        .op_kind   (op_kind),
        .op_data   (op_data),
        .ptr_q     (ptr_q),
        .mark_q    (mark_q),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .seg_we    (seg_we),
        .seg_wdata (seg_wdata),
        .ptr_we    (ptr_we),
        .ptr_wdata (ptr_wdata),
        .mark_we   (mark_we),
        .req_q     (req_q),
        .busy      (busy),
        .pop_valid (pop_valid),
        .pop_data  (pop_data),
        .underflow (underflow)
    );

    segstk_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .seg_we    (seg_we),
        .seg_wdata (seg_wdata),
        .ptr_we    (ptr_we),
        .ptr_wdata (ptr_wdata),
        .mark_we   (mark_we),
        .seg_q     (seg_q),
        .ptr_q     (ptr_q),
        .mark_q    (mark_q)
    );

    segstk_agen u_agen (
        .seg  (seg_q),
        .off  (req_q.off),
        .addr (pa)
    );

    assign seg_val   = seg_q;
    assign ptr_val   = ptr_q;
    assign mem_req   = req_q.valid;
    assign mem_we    = req_q.wr;
    assign mem_addr  = pa;
    assign mem_wdata = req_q.wdata;

    // R8
    busy_req_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    // R8
    seg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_ack) |=> $stable(seg_val));

endmodule

// File: tb/seg_stack_engine_tb.sv
module seg_stack_engine_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [1:0]  op_kind;
    logic [15:0] op_data;
    logic        busy, underflow, pop_valid;
    logic [15:0] pop_data, seg_val, ptr_val;
    logic        mem_req, mem_we;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ack;
    logic [15:0] mem_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_stack_engine dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
        .op_data(op_data), .busy(busy), .underflow(underflow),
        .pop_valid(pop_valid), .pop_data(pop_data), .seg_val(seg_val),
        .ptr_val(ptr_val), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    // word memory model: acknowledges one cycle after a request appears
    logic [15:0] mem [logic [19:0]];
    always @(posedge clk) begin
        if (rst) begin
            mem_ack   <= 1'b0;
            mem_rdata <= 16'h0000;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr] = mem_wdata;
            else mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 16'hDEAD;
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
        end
    endtask

    logic        g_req, g_we, g_pv, g_uf;
    logic [19:0] g_addr;
    logic [15:0] g_pd;

    task automatic do_op(input logic [1:0] k, input logic [15:0] d);
        g_req = 0; g_we = 0; g_pv = 0; g_uf = 0; g_addr = '0; g_pd = '0;
        @(negedge clk);
        op_valid = 1'b1; op_kind = k; op_data = d;
        @(negedge clk);
        op_valid = 1'b0;
        while (1) begin
            if (mem_req) begin g_req = 1; g_we = mem_we; g_addr = mem_addr; end
            if (underflow) g_uf = 1;
            if (pop_valid) begin g_pv = 1; g_pd = pop_data; end
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    typedef struct packed {
        logic [1:0]  op;
        logic [15:0] d;
        logic [15:0] seg;
        logic [15:0] sp;
        logic        req;
        logic [19:0] addr;
        logic        pv;
        logic [15:0] pd;
        logic        uf;
    } vec_t;

    localparam vec_t VEC [17] = '{
        '{2'b11, 16'h0000, 16'h0000, 16'h0000, 1'b0, 20'h00000, 1'b0, 16'h0000, 1'b1},
        '{2'b00, 16'h5000, 16'h5000, 16'h0000, 1'b0, 20'h00000, 1'b0, 16'h0000, 1'b0},
        '{2'b01, 16'h7000, 16'h5000, 16'h7000, 1'b0, 20'h00000, 1'b0, 16'h0000, 1'b0},
        '{2'b10, 16'h1111, 16'h5000, 16'h6FFE, 1'b1, 20'h56FFE, 1'b0, 16'h0000, 1'b0},
        '{2'b10, 16'h2222, 16'h5000, 16'h6FFC, 1'b1, 20'h56FFC, 1'b0, 16'h0000, 1'b0},
        '{2'b11, 16'h0000, 16'h5000, 16'h6FFE, 1'b1, 20'h56FFC, 1'b1, 16'h2222, 1'b0},
        '{2'b11, 16'h0000, 16'h5000, 16'h7000, 1'b1, 20'h56FFE, 1'b1, 16'h1111, 1'b0},
        '{2'b11, 16'h0000, 16'h5000, 16'h7000, 1'b0, 20'h00000, 1'b0, 16'h0000, 1'b1},
        '{2'b00, 16'hFFFF, 16'hFFFF, 16'h7000, 1'b0, 20'h00000, 1'b0, 16'h0000, 1'b0},
        '{2'b01, 16'h0020, 16'hFFFF, 16'h0020, 1'b0, 20'h00000, 1'b0, 16'h0000, 1'b0},
        '{2'b10, 16'hABCD, 16'hFFFF, 16'h001E, 1'b1, 20'h0000E, 1'b0, 16'h0000, 1'b0},
        '{2'b11, 16'h0000, 16'hFFFF, 16'h0020, 1'b1, 20'h0000E, 1'b1, 16'hABCD, 1'b0},
        '{2'b00, 16'h0000, 16'h0000, 16'h0020, 1'b0, 20'h00000, 1'b0, 16'h0000, 1'b0},
        '{2'b01, 16'h0000, 16'h0000, 16'h0000, 1'b0, 20'h00000, 1'b0, 16'h0000, 1'b0},
        '{2'b10, 16'h5A5A, 16'h0000, 16'hFFFE, 1'b1, 20'h0FFFE, 1'b0, 16'h0000, 1'b0},
        '{2'b11, 16'h0000, 16'h0000, 16'h0000, 1'b1, 20'h0FFFE, 1'b1, 16'h5A5A, 1'b0},
        '{2'b11, 16'h0000, 16'h0000, 16'h0000, 1'b0, 20'h00000, 1'b0, 16'h0000, 1'b1}
    };

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int lifo_bad;
        rst = 1'b1; op_valid = 1'b0; op_kind = 2'b00; op_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        chk("R1 seg", 20'(seg_val), 20'h0);
        chk("R1 ptr", 20'(ptr_val), 20'h0);
        chk("R1 busy/req", {18'b0, busy, mem_req}, 20'h0);
        chk("R1 pulses", {18'b0, pop_valid, underflow}, 20'h0);

        // table walk: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < 17; i++) begin
            do_op(VEC[i].op, VEC[i].d);
            chk($sformatf("R6 seg v%0d", i), 20'(seg_val), 20'(VEC[i].seg));
            chk($sformatf("R2/R3/R5 ptr v%0d", i), 20'(ptr_val), 20'(VEC[i].sp));
            chk($sformatf("R6/R7 req v%0d", i), 20'(g_req), 20'(VEC[i].req));
            if (VEC[i].req) begin
                chk($sformatf("R4 addr v%0d", i), g_addr, VEC[i].addr);
                chk($sformatf("R2/R3 we v%0d", i), 20'(g_we), 20'(VEC[i].op == 2'b10));
            end
            chk($sformatf("R3 pop_valid v%0d", i), 20'(g_pv), 20'(VEC[i].pv));
            if (VEC[i].pv) chk($sformatf("R3 pop_data v%0d", i), 20'(g_pd), 20'(VEC[i].pd));
            chk($sformatf("R7 underflow v%0d", i), 20'(g_uf), 20'(VEC[i].uf));
        end

        // R8: command offered while busy is ignored
        do_op(2'b01, 16'h0100);
        @(negedge clk);
        op_valid = 1'b1; op_kind = 2'b10; op_data = 16'h7777;
        @(negedge clk);
        op_kind = 2'b01; op_data = 16'h1234;
        chk("R8 busy during push", 20'(busy), 20'h1);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R8 ptr after ignored load", 20'(ptr_val), 20'h00FE);
        do_op(2'b11, 16'h0);
        chk("R8 pop after ignored load", 20'(g_pd), 20'h7777);
        chk("R8 ptr back to mark", 20'(ptr_val), 20'h0100);

        // R9 long run
        do_op(2'b00, 16'h5000);
        do_op(2'b01, 16'h7000);
        for (int i = 0; i < 6144; i++) do_op(2'b10, 16'(i));
        chk("R9 ptr after 6144 pushes", 20'(ptr_val), 20'h4000);
        lifo_bad = 0;
        for (int i = 0; i < 4096; i++) begin
            do_op(2'b11, 16'h0);
            if (!g_pv || g_pd !== 16'(6143 - i)) lifo_bad++;
        end
        chk("R9 ptr after 4096 pops", 20'(ptr_val), 20'h6000);
        chk("R9 seg unchanged", 20'(seg_val), 20'h5000);
        chk("R9 lifo order errors", 20'(lifo_bad), 20'h0);

        // R1 reset mid-stack clears state; pop then underflows
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 ptr after reset", 20'(ptr_val), 20'h0);
        do_op(2'b11, 16'h0);
        chk("R1 underflow after reset", 20'(g_uf), 20'h1);

        finish_run();
    end

endmodule